// File: doc/BRIEF.md
# Compare Timer with Match-Clear

This block is a free-running up-counter with two compare channels. The counter advances by one on every clock cycle in which the count tick input is high. A channel takes part in comparison only when both of its two mode bits are set. A match is judged on the value that a tick has just produced. Each match gives a one-cycle interrupt pulse on that channel's output and toggles a single timer output pin.

Channel 0 can also restart the count. When the clear-enable bit is set and channel 0 matches, the next tick loads zero in place of the increment. A compare value of zero is special. It matches only when the counter rolls over from all ones to zero. It does not match the zero present after reset, and it does not match the zero loaded by a clear.

Configuration is held in plain registers. The mode bits and the clear-enable bit are loaded together by one strobe. Each compare value has its own write strobe and shares one data bus with the other. None of these are streams, so there is no back-pressure. A write takes effect for ticks from the following cycle on.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset `cnt_o` is 0, `irq_o` is all zero and `to_o` is low. `cnt_o` changes only at a clock edge where `tick_i` was high.
- R2: A channel whose 2-bit mode field is anything other than 2'b11 never raises its interrupt. Channel i's field sits at `cfg_mode_i[2i+1:2i]`.
- R3: A tick that moves the counter to a nonzero value equal to a compare-mode channel's value raises that channel's `irq_o` bit. The pulse lasts exactly the one cycle in which `cnt_o` first shows the value.
- R4: A compare value of 0 matches when a tick takes the counter from all ones to zero.
- R5: The zero held by the counter after reset, before any tick, never produces a match.
- R6: With clear enabled, a channel 0 match makes the next tick load 0 instead of incrementing. Neither channel matches that zero.
- R7: A channel 1 match never alters the count sequence.
- R8: `to_o` inverts once on each tick that produces a match on one or more channels. When both channels match on the same tick, it inverts only once.
- R9: Without a clear, the counter wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| tick_i | input | 1 | Count enable; counting and matching happen only on high cycles |
| cfg_wr_i | input | 1 | Strobe that loads the mode bits and the clear-enable bit |
| cfg_mode_i | input | 2*NCH | Mode field per channel; 2'b11 selects compare |
| cfg_clr_en_i | input | 1 | Allows a channel 0 match to clear the counter |
| cmp_wr_i | input | NCH | Per-channel compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value to write |
| cnt_o | output | CNT_W | Current counter value |
| irq_o | output | NCH | Per-channel single-cycle match pulse |
| to_o | output | 1 | Timer output, toggled on matches |

## Verification
The hardest case to reach is the clear cycle combined with a zero compare. The counter must go through a full rollover so that a zero compare matches. With clear enabled, a channel 0 match must then be followed by a tick that loads zero, and that zero must not match again. With 16-bit defaults, reaching this takes tens of thousands of ticks. The bench therefore builds the block with a 4-bit counter. It sweeps every channel 0 compare value with clear both off and on, and it varies the tick spacing and the mode fields. Each run starts from reset, so the power-up zero is exercised in every run.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam logic [1:0] MODE_COMPARE = 2'b11;

  typedef struct packed {
    logic [1:0] mode;
  } chan_cfg_t;
endpackage

// File: rtl/tcu_counter.sv
module tcu_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_set_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             zero_ok_o,
  output logic             clr_pend_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             clr_pend_q;
  logic             at_top;

  always_comb begin
    at_top    = (cnt_q == {CNT_W{1'b1}});
    cnt_nxt_o = clr_pend_q ? '0 : cnt_q + 1'b1;
    zero_ok_o = at_top && !clr_pend_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      clr_pend_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q      <= cnt_nxt_o;
      clr_pend_q <= clr_set_i;
    end
  end

  assign cnt_q_o    = cnt_q;
  assign clr_pend_o = clr_pend_q;
endmodule

// File: rtl/tcu_cmp_chan.sv
module tcu_cmp_chan
  import tcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  chan_cfg_t        cfg_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             zero_ok_i,
  output logic             hit_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             irq_q;
  logic             is_zero;

  always_comb begin
    is_zero = (cnt_nxt_i == '0);
    hit_o   = tick_i && (cfg_i.mode == MODE_COMPARE) &&
              (cnt_nxt_i == cmp_q) && (!is_zero || zero_ok_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_i) cmp_q <= wdata_i;
      irq_q <= hit_o;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tcu_out.sv
module tcu_out #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit_i,
  output logic           pin_o
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (|hit_i) pin_q <= ~pin_q;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
  import tcu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cfg_wr_i,
  input  logic [2*NCH-1:0] cfg_mode_i,
  input  logic             cfg_clr_en_i,
  input  logic [NCH-1:0]   cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [NCH-1:0]   irq_o,
  output logic             to_o
);
  chan_cfg_t        cfg_q [NCH];
  logic [2*NCH-1:0] mode_flat;
  logic             clr_en_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             zero_ok;
  logic             clr_pend;
  logic [NCH-1:0]   hit;
  logic             clr_set;

  always_ff @(posedge clk) begin
    if (!rst_n) clr_en_q <= 1'b0;
    else if (cfg_wr_i) clr_en_q <= cfg_clr_en_i;
  end

  assign clr_set = hit[0] && clr_en_q;

  tcu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .clr_set_i (clr_set),
    .cnt_q_o   (cnt_o),
    .cnt_nxt_o (cnt_nxt),
    .zero_ok_o (zero_ok),
    .clr_pend_o(clr_pend)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) cfg_q[c].mode <= 2'b00;
      else if (cfg_wr_i) cfg_q[c].mode <= cfg_mode_i[2*c +: 2];
    end
    assign mode_flat[2*c +: 2] = cfg_q[c].mode;

    tcu_cmp_chan #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (cmp_wr_i[c]),
      .wdata_i  (cmp_wdata_i),
      .cfg_i    (cfg_q[c]),
      .tick_i   (tick_i),
      .cnt_nxt_i(cnt_nxt),
      .zero_ok_i(zero_ok),
      .hit_o    (hit[c]),
      .irq_o    (irq_o[c])
    );
  end

  tcu_out #(.NCH(NCH)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .hit_i(hit),
    .pin_o(to_o)
  );
endmodule

// File: rtl/tmr_cmp_unit_chk.sv
module tmr_cmp_unit_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [NCH-1:0]   irq_o,
  input logic             to_o,
  input logic             clr_pend,
  input logic [2*NCH-1:0] mode_flat
);
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_o)); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clr_pend) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R9

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && clr_pend) |=> (cnt_o == '0 && irq_o == '0)); // R6

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> (irq_o == '0)); // R3

  AST_TO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |-> (to_o != $past(to_o))); // R8

  AST_TO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o == '0) |-> $stable(to_o)); // R8

  for (genvar c = 0; c < NCH; c++) begin : g_mode
    AST_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> ($past(mode_flat[2*c +: 2]) == 2'b11)); // R2
  end
endmodule

bind tmr_cmp_unit tmr_cmp_unit_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_i   (tick_i),
  .cnt_o    (cnt_o),
  .irq_o    (irq_o),
  .to_o     (to_o),
  .clr_pend (clr_pend),
  .mode_flat(mode_flat)
);

// File: tb/tmr_cmp_unit_bench.sv
module tmr_cmp_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 4;
  localparam int NCH = 2;
  localparam int TOP = (1 << W) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick_i = 1'b0;
  logic           cfg_wr_i = 1'b0;
  logic [3:0]     cfg_mode_i = '0;
  logic           cfg_clr_en_i = 1'b0;
  logic [1:0]     cmp_wr_i = '0;
  logic [W-1:0]   cmp_wdata_i = '0;
  logic [W-1:0]   cnt_o;
  logic [1:0]     irq_o;
  logic           to_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int  e_cnt, c0, c1;
  bit  e_pend, e_to, clr, m0ok, m1ok;
  logic [1:0] e_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_cmp_unit #(.CNT_W(W), .NCH(NCH)) u_tmr_cmp_unit (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_wr_i(cfg_wr_i),
    .cfg_mode_i(cfg_mode_i), .cfg_clr_en_i(cfg_clr_en_i),
    .cmp_wr_i(cmp_wr_i), .cmp_wdata_i(cmp_wdata_i),
    .cnt_o(cnt_o), .irq_o(irq_o), .to_o(to_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    e_cnt = 0; e_pend = 0; e_to = 0; e_irq = '0;
    chk(cnt_o == 0, "R1 reset count", int'(cnt_o), 0);
    chk(irq_o == 0 && to_o == 0, "R1 reset irq/pin", int'({irq_o, to_o}), 0);
  endtask

  task automatic step(input bit t);
    int  nxt;
    bit  zok, h0, h1, was_pend;
    string tag;
    @(negedge clk);
    tick_i = t;
    @(posedge clk);
    was_pend = e_pend;
    h0 = 0; h1 = 0;
    if (t) begin
      zok = (e_cnt == TOP) && !e_pend;
      nxt = e_pend ? 0 : (e_cnt + 1) % (TOP + 1);
      h0  = m0ok && nxt == c0 && (nxt != 0 || zok);
      h1  = m1ok && nxt == c1 && (nxt != 0 || zok);
      e_pend = h0 && clr;
      if (h0 || h1) e_to = !e_to;
      e_cnt = nxt;
    end
    e_irq = {h1, h0};
    #(CLK_PERIOD/4);
    tick_i = 1'b0;
    if (t && was_pend)            tag = "R6 clear cycle";
    else if (t && e_cnt == 0)     tag = "R4 R5 zero value";
    else if (!m0ok || !m1ok)      tag = "R2 mode gate";
    else                          tag = "R3 match pulse";
    chk(irq_o == e_irq, tag, int'(irq_o), int'(e_irq));
    chk(int'(cnt_o) == e_cnt, (c1 == e_cnt && clr) ? "R7 count sequence" : "R1 R9 count",
        int'(cnt_o), e_cnt);
    chk(to_o == e_to, "R8 timer pin", int'(to_o), int'(e_to));
  endtask

  initial begin
    for (int a = 0; a <= TOP; a++) begin
      for (int k = 0; k < 2; k++) begin
        c0  = a;
        c1  = (a % 3 == 0) ? a : (a * 5 + 3) % (TOP + 1);
        clr = (k == 1);
        m0ok = (a % 4 != 3);
        m1ok = (a % 5 != 4);
        do_reset();
        @(negedge clk);
        cfg_wr_i = 1'b1;
        cfg_mode_i = {(m1ok ? 2'b11 : 2'b10), (m0ok ? 2'b11 : 2'b01)};
        cfg_clr_en_i = clr;
        cmp_wr_i = 2'b01; cmp_wdata_i = W'(c0);
        @(negedge clk);
        cfg_wr_i = 1'b0;
        cmp_wr_i = 2'b10; cmp_wdata_i = W'(c1);
        @(negedge clk);
        cmp_wr_i = 2'b00;
        // R5: a few idle cycles at the power-up zero, no tick, no match
        for (int i = 0; i < 3; i++) step(1'b0);
        for (int i = 0; i < 44; i++) step((a % 2 == 1) ? (i % 3 != 2) : 1'b1);
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule